// File: doc/BRIEF.md
# Dual-Mode Interval/Toggle Timer

A 32-bit down-counting timer with one output pin. Software writes a timeout value, then sets the enable bit. The counter then runs down to zero, reloads and starts again, and keeps doing so until it is disabled. A timeout value of N gives one timeout every N+1 clocks.

A mode bit selects how each timeout shapes the output. In interval mode the output rests low and goes high for a single clock after each timeout. In toggle mode the output changes level at each timeout, which gives a square wave of period 2(N+1).

A small register port lets software read the live count and a sticky timeout flag. The flag is cleared by writing one to it.

Top module: `dual_timer`

## Requirements
- R1: After reset, enable, mode, timeout value, count and status all read 0, and `timer_o` is low.
- R2: When a write to the control register moves the enable bit from 0 to 1, the count takes the timeout register's value as it stood before that write cycle. Writing enable=1 while the timer is already enabled does not reload the count.
- R3: While the timer is enabled, the count decrements by one every clock. When the count is 0, a timeout occurs and the count reloads from the timeout register, so a timeout value of N gives a period of N+1 clocks.
- R4: In interval mode (control bit 1 = 0), `timer_o` is low except for one clock following each timeout, when it is high.
- R5: In toggle mode (control bit 1 = 1), `timer_o` inverts in the clock following each timeout and holds its level between timeouts.
- R6: The status register (address 3, bit 0) is set by every timeout and stays set until a write to address 3 with bit 0 = 1. Writing bit 0 = 0 has no effect. If a timeout and a clear fall in the same cycle, the timeout wins.
- R7: While the timer is disabled, the count holds its value and `timer_o` is low. The toggle level restarts low on the next enable.
- R8: Register map, with a 2-bit address: 0 is control (bit 0 enable, bit 1 mode); 1 is the timeout value; 2 is the count, which is read-only, so writes to it are ignored; 3 is status. Unused read bits are 0.
- R9: A timeout value of 0 produces a timeout on every enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i`, combinational |
| timer_o | output | 1 | Timer output |

## Verification
The bench targets these corner cases:

- **Timeout value of 0.** The timer must fire on every clock. An off-by-one reload would skip cycles or stall.
- **Setting enable while already enabled.** A design that reloads here would stretch the current period.
- **Disabling in the middle of a toggle period.** A design that kept the toggle level would restart high, or would keep driving the pin while disabled.
- **Clearing the status flag.** A write of 0 must not clear it, and a clear that coincides with a timeout must lose. Getting either wrong loses a timeout event.
- **Writes to the count address.** These must leave the running count untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] RA_CTRL    = 2'd0;
  localparam logic [ADDR_W-1:0] RA_TIMEOUT = 2'd1;
  localparam logic [ADDR_W-1:0] RA_COUNT   = 2'd2;
  localparam logic [ADDR_W-1:0] RA_STATUS  = 2'd3;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MODE_BIT = 1;
  typedef enum logic {MODE_INTERVAL = 1'b0, MODE_TOGGLE = 1'b1} tmr_mode_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 tick_i,
  output logic                 en_o,
  output tmr_mode_e            mode_o,
  output logic [CNT_W-1:0]     load_o,
  output logic                 start_o,
  output logic [CNT_W-1:0]     rd_data_o
);
  logic en_q, status_q, clr;
  tmr_mode_e mode_q;
  logic [CNT_W-1:0] load_q;

  wire wr_ctrl = wr_en_i && (wr_addr_i == RA_CTRL);
  assign start_o = wr_ctrl && wr_data_i[CTRL_EN_BIT] && !en_q;
  assign clr     = wr_en_i && (wr_addr_i == RA_STATUS) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      mode_q   <= MODE_INTERVAL;
      load_q   <= '0;
      status_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wr_data_i[CTRL_EN_BIT];
        mode_q <= tmr_mode_e'(wr_data_i[CTRL_MODE_BIT]);
      end
      if (wr_en_i && (wr_addr_i == RA_TIMEOUT)) load_q <= wr_data_i;
      // timeout takes priority over clear
      if (tick_i)   status_q <= 1'b1;
      else if (clr) status_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      RA_CTRL: begin
        rd_data_o[CTRL_EN_BIT]   = en_q;
        rd_data_o[CTRL_MODE_BIT] = mode_q;
      end
      RA_TIMEOUT: rd_data_o    = load_q;
      RA_COUNT:   rd_data_o    = cnt_i;
      default:    rd_data_o[0] = status_q;
    endcase
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign load_o = load_q;

  a_r6_set_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> status_q);
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !clr) |=> status_q);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= load_i;
    else if (tick_o)  cnt_q <= load_i;
    else if (en_i)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r2_load_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == $past(load_i));
  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_shaper.sv
module tmr_shaper
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  tmr_mode_e mode_i,
  input  logic      tick_i,
  output logic      timer_o
);
  logic pulse_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      pulse_q <= tick_i;
      tog_q   <= en_i ? (tog_q ^ tick_i) : 1'b0;
    end
  end

  assign timer_o = en_i && ((mode_i == MODE_TOGGLE) ? tog_q : pulse_q);

  a_r4_pulse_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> pulse_q);
  a_r5_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> tog_q != $past(tog_q));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(tog_q));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              timer_o
);
  logic             en, start, tick;
  tmr_mode_e        mode;
  logic [CNT_W-1:0] load, cnt;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .cnt_i(cnt), .tick_i(tick), .en_o(en), .mode_o(mode), .load_o(load),
    .start_o(start), .rd_data_o
  );

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .en_i(en), .start_i(start), .load_i(load),
    .cnt_o(cnt), .tick_o(tick)
  );

  tmr_shaper u_shaper (
    .clk_i, .rst_ni, .en_i(en), .mode_i(mode), .tick_i(tick), .timer_o
  );

  a_r7_low_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !timer_o);
endmodule

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tmr_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_timer u_dual_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .timer_o(tmr_out)
  );

  // behavioural reference state
  bit m_en, m_mode, m_pulse, m_tog, m_st;
  logic [31:0] m_load, m_cnt;

  always @(posedge clk) begin
    bit tick, start, clr;
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_pulse = 0; m_tog = 0; m_st = 0; m_load = 0; m_cnt = 0;
    end else begin
      tick  = m_en && (m_cnt == 0);
      start = wr_en && wr_addr == 2'd0 && wr_data[0] && !m_en;
      clr   = wr_en && wr_addr == 2'd3 && wr_data[0];
      m_pulse = tick;
      m_tog   = m_en ? (m_tog ^ tick) : 1'b0;
      if (start || tick) m_cnt = m_load;
      else if (m_en)     m_cnt = m_cnt - 1;
      if (tick)     m_st = 1;
      else if (clr) m_st = 0;
      if (wr_en && wr_addr == 2'd0) begin m_en = wr_data[0]; m_mode = wr_data[1]; end
      if (wr_en && wr_addr == 2'd1) m_load = wr_data;
    end
  end

  function automatic logic [31:0] exp_rd();
    case (rd_addr)
      2'd0:    return {30'd0, m_mode, m_en};
      2'd1:    return m_load;
      2'd2:    return m_cnt;
      default: return {31'd0, m_st};
    endcase
  endfunction

  // per-cycle comparison, well away from the active edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      logic [31:0] e;
      bit eo;
      e  = exp_rd();
      eo = m_en && (m_mode ? m_tog : m_pulse);
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%0h expected=%0h",
                 rd_addr == 2'd2 ? "R3 count" : rd_addr == 2'd3 ? "R6 status" : "R8 reg",
                 rd_addr, rd_data, e);
      end
      checks++;
      if (tmr_out !== eo) begin
        errors++;
        $display("FAIL %s timer_o actual=%0b expected=%0b t=%0t",
                 !m_en ? "R7" : m_mode ? "R5" : "R4", tmr_out, eo, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run(input logic [1:0] ra, input int n);
    @(negedge clk);
    rd_addr = ra;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      checks++;
      if (rd_data !== 32'd0) begin
        errors++;
        $display("FAIL R1 addr=%0d actual=%0h expected=0", a, rd_data);
      end
    end
    checks++;
    if (tmr_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 timer_o actual=%0b expected=0", tmr_out);
    end
    // R2, R3, R4: interval mode with period 6
    wr(2'd1, 32'd5);
    wr(2'd0, 32'h1);
    run(2'd2, 20);
    run(2'd3, 4);
    // R6: write 0 does nothing; write 1 clears
    wr(2'd3, 32'h0);
    wr(2'd3, 32'h1);
    run(2'd3, 8);
    // R2: mode change while enabled must not reload; R5 toggle
    wr(2'd0, 32'h3);
    run(2'd2, 25);
    // R8: writes to the count address are ignored
    wr(2'd2, 32'hDEAD_BEEF);
    run(2'd2, 6);
    // R7: disable mid-period holds count, output low
    wr(2'd0, 32'h2);
    run(2'd2, 10);
    // R9: timeout 0 fires every clock
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h1);
    run(2'd2, 6);
    wr(2'd0, 32'h3);
    run(2'd3, 6);
    // R6: clear collides with a timeout every cycle; the timeout wins
    wr(2'd3, 32'h1);
    run(2'd3, 3);
    // R7: restart in toggle mode begins low
    wr(2'd0, 32'h0);
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h3);
    run(2'd0, 4);
    run(2'd2, 20);
    // R8: large timeout read-back and running count
    wr(2'd1, 32'hFFFF_FFF0);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h1);
    run(2'd1, 3);
    run(2'd2, 5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule